// File: doc/BRIEF.md
# Serial Radio Frame Receiver

This block sits behind a radio front end that has already recovered the bit timing. It takes one received bit on every rising edge of the recovered bit clock. While idle it searches the incoming bits for a 16-bit start-of-frame delimiter. When the delimiter is found, it reads the rest of the frame in this order: a 6-bit payload length, a 38-bit link header, the payload bytes, and a 16-bit check word. The end of the frame is known only from the length field, because there is no closing delimiter.

The parsed header fields, together with the length, appear on dedicated outputs with a one-cycle `hdr_valid` pulse. Payload bytes are delivered one at a time on a byte-wide output, each marked by a `byte_valid` pulse. The final byte also raises `byte_last`. After the 16th check bit, `frame_done` pulses and `crc_ok` reports in the same cycle whether the check matched. The receiver then goes back to searching for a delimiter.

The controller has five states:
- `S_HUNT`: searching for the delimiter.
- `S_LEN`: receiving the length field.
- `S_HDR`: receiving the header.
- `S_PAY`: receiving the payload.
- `S_CRC`: receiving the check word.

It has six transitions:
- `S_HUNT`→`S_LEN` on a delimiter match.
- `S_LEN`→`S_HDR` after the 6th length bit.
- `S_HDR`→`S_PAY` after the 38th header bit when the length is non-zero.
- `S_HDR`→`S_CRC` after the 38th header bit when the length is zero.
- `S_PAY`→`S_CRC` after the last bit of the last byte.
- `S_CRC`→`S_HUNT` after the 16th check bit.

Top module: `radio_frame_rx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all strobes (`hdr_valid`, `byte_valid`, `byte_last`, `frame_done`, `crc_ok`) are low and the receiver is searching for a delimiter.
- R2: A frame starts only when the last 16 bits received while searching equal the delimiter parameter (default 16'hF3A5), with the most significant bit received first. Streams that never contain the delimiter, or that contain only a 15-bit prefix of it, produce no strobes.
- R3: The 6 bits that follow the delimiter are the payload length in bytes, most significant bit first. This value appears on `frm_len` together with `hdr_valid`.
- R4: The 38 header bits that follow the length are decoded as follows, first received bit first: transmitter address (6 bits), receiver address (6), source address (6), destination address (6), kind (3), ack (1), reserved (1), sequence number (8), more flag (1). `hdr_valid` pulses for one cycle, in the cycle after the 38th header bit is sampled. The header outputs hold their values until the next header.
- R5: For a non-zero length N, exactly N bytes are delivered, each assembled most significant bit first. `byte_valid` pulses in the cycle after each byte's 8th bit is sampled. `byte_last` is high only together with the N-th byte, and no more bytes are ever read than the length field gives.
- R6: When the length is zero, no payload byte is delivered and the check word follows the header directly.
- R7: The check is computed bit-serially over the length, header and payload bits with the CRC-16 polynomial 0x1021 and a starting value of 0xFFFF. It is compared with the 16 received check bits, most significant first. `frame_done` pulses in the cycle after the 16th check bit is sampled, and `crc_ok` is 1 exactly when the two values are equal.
- R8: `crc_ok` is never high unless `frame_done` is high in the same cycle.
- R9: After a frame, the receiver searches again and needs a complete new delimiter. Bits received inside a frame never count toward a delimiter, so delimiter patterns inside the payload do not restart parsing. A frame whose delimiter immediately follows the previous check word is received correctly.
- R10: At most one of `hdr_valid`, `byte_valid` and `frame_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock; one received bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial bit |
| hdr_valid | output | 1 | One-cycle pulse: header fields and length are updated |
| hdr_tx_addr | output | 6 | Transmitter address |
| hdr_rx_addr | output | 6 | Receiver address |
| hdr_src_addr | output | 6 | Source address |
| hdr_dst_addr | output | 6 | Destination address |
| hdr_kind | output | 3 | Frame kind |
| hdr_ack | output | 1 | Acknowledge-request flag |
| hdr_rsvd | output | 1 | Reserved header bit |
| hdr_seq | output | 8 | Sequence number |
| hdr_more | output | 1 | More-fragments flag |
| frm_len | output | 6 | Payload length in bytes |
| byte_data | output | 8 | Payload byte |
| byte_valid | output | 1 | One-cycle pulse: `byte_data` holds a payload byte |
| byte_last | output | 1 | Marks the final payload byte of the frame |
| frame_done | output | 1 | One-cycle pulse after the last check bit |
| crc_ok | output | 1 | Check result, valid with `frame_done` |

## Verification
The assertions check the following on every cycle:
- the three strobes never overlap;
- `crc_ok` and `byte_last` appear only with their companion strobe;
- the payload byte counter stays below the received length;
- a zero length never enters the payload state;
- every `frame_done` coincides with the return to searching.

Only the bench scenarios can show the rest:
- that the delimiter is recognised in random streams and not in partial ones;
- that header fields land in the right bit positions;
- that payload bytes arrive in order and with the correct values;
- that the check result matches an independently computed CRC, for both good and corrupted check words;
- that back-to-back frames and embedded delimiter patterns are handled correctly.

// File: rtl/radio_rx_pkg.sv
package radio_rx_pkg;

    localparam int LEN_W  = 6;
    localparam int HDR_W  = 38;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [2:0] {
        S_HUNT,
        S_LEN,
        S_HDR,
        S_PAY,
        S_CRC
    } rx_state_e;

    // first received header bit is the MSB of tx_addr
    typedef struct packed {
        logic [5:0] tx_addr;
        logic [5:0] rx_addr;
        logic [5:0] src_addr;
        logic [5:0] dst_addr;
        logic [2:0] kind;
        logic       ack;
        logic       rsvd;
        logic [7:0] seq;
        logic       more;
    } mac_hdr_t;

endpackage

// File: rtl/delim_detect.sv
module delim_detect #(
    parameter int           W       = 16,
    parameter logic [W-1:0] PATTERN = 16'hF3A5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    output logic hit
);

    localparam int FILL_W = $clog2(W + 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(W - 1);

    logic [W-2:0]      hist;
    logic [FILL_W-1:0] fill;

    // match on the bits already held plus the current one
    assign hit = en && (fill == FULL) && ({hist, bit_in} == PATTERN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
        end else if (hit) begin
            hist <= '0;
            fill <= '0;
        end else if (en) begin
            hist <= {hist[W-3:0], bit_in};
            if (fill != FULL) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // R9: a consumed delimiter must be rebuilt from fresh bits
    a_r9_no_back_to_back_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/crc16_serial.sv
module crc16_serial #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021,
    parameter logic [W-1:0] INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] crc
);

    logic         fb;
    logic [W-1:0] crc_n;

    assign fb    = crc[W-1] ^ bit_in;
    assign crc_n = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= INIT;
        end else if (init) begin
            crc <= INIT;
        end else if (en) begin
            crc <= crc_n;
        end
    end

    // R7: restart and accumulate are never requested together
    a_r7_init_en_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(init && en));

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import radio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              delim_hit,
    input  logic [CRC_W-1:0]  crc_calc,
    output logic              hunt_en,
    output logic              crc_init,
    output logic              crc_en,
    output logic              hdr_valid,
    output mac_hdr_t          hdr_q,
    output logic [LEN_W-1:0]  frm_len,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              byte_last,
    output logic              frame_done,
    output logic              crc_ok
);

    localparam int CNT_W = $clog2(HDR_W);
    localparam logic [CNT_W-1:0] LEN_END  = CNT_W'(LEN_W - 1);
    localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);

    rx_state_e          state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   byte_cnt;
    logic [HDR_W-2:0]   hdr_sh;
    logic [BYTE_W-2:0]  byte_sh;
    logic [CRC_W-2:0]   crc_sh;
    logic               byte_end;
    logic               final_byte;

    assign byte_end   = (state == S_PAY) && (cnt == BYTE_END);
    assign final_byte = (byte_cnt == len_q - LEN_W'(1));

    assign hunt_en  = (state == S_HUNT);
    assign crc_init = delim_hit;
    assign crc_en   = (state == S_LEN) || (state == S_HDR) || (state == S_PAY);

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_HUNT: if (delim_hit) state_n = S_LEN;
            S_LEN:  if (cnt == LEN_END) state_n = S_HDR;
            S_HDR:  if (cnt == HDR_END) state_n = (len_q == '0) ? S_CRC : S_PAY;
            S_PAY:  if (byte_end && final_byte) state_n = S_CRC;
            S_CRC:  if (cnt == CRC_END) state_n = S_HUNT;
            default: state_n = S_HUNT;
        endcase
    end

    always_comb begin
        if (state_n != state || byte_end || state == S_HUNT) begin
            cnt_n = '0;
        end else begin
            cnt_n = cnt + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HUNT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // field capture and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q      <= '0;
            byte_cnt   <= '0;
            hdr_sh     <= '0;
            byte_sh    <= '0;
            crc_sh     <= '0;
            hdr_q      <= '0;
            frm_len    <= '0;
            byte_data  <= '0;
            hdr_valid  <= 1'b0;
            byte_valid <= 1'b0;
            byte_last  <= 1'b0;
            frame_done <= 1'b0;
            crc_ok     <= 1'b0;
        end else begin
            hdr_valid  <= 1'b0;
            byte_valid <= 1'b0;
            byte_last  <= 1'b0;
            frame_done <= 1'b0;
            crc_ok     <= 1'b0;
            unique case (state)
                S_HUNT: begin
                    if (delim_hit) byte_cnt <= '0;
                end
                S_LEN: begin
                    len_q <= {len_q[LEN_W-2:0], rx_bit};
                end
                S_HDR: begin
                    hdr_sh <= {hdr_sh[HDR_W-3:0], rx_bit};
                    if (cnt == HDR_END) begin
                        hdr_q     <= mac_hdr_t'({hdr_sh, rx_bit});
                        frm_len   <= len_q;
                        hdr_valid <= 1'b1;
                    end
                end
                S_PAY: begin
                    byte_sh <= {byte_sh[BYTE_W-3:0], rx_bit};
                    if (byte_end) begin
                        byte_data  <= {byte_sh, rx_bit};
                        byte_valid <= 1'b1;
                        byte_last  <= final_byte;
                        byte_cnt   <= byte_cnt + 1'b1;
                    end
                end
                S_CRC: begin
                    crc_sh <= {crc_sh[CRC_W-3:0], rx_bit};
                    if (cnt == CRC_END) begin
                        frame_done <= 1'b1;
                        crc_ok     <= (crc_calc == {crc_sh, rx_bit});
                    end
                end
                default: ;
            endcase
        end
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_valid, byte_valid, frame_done}));

    a_r8_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> frame_done);

    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> byte_valid);

    a_r5_bytes_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAY) |-> (byte_cnt < len_q));

    a_r6_zero_len_skips_pay: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && frm_len == '0) |-> (state == S_CRC));

    a_r4_hdr_then_body: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (state == S_PAY || state == S_CRC));

    a_r9_done_back_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (state == S_HUNT));

endmodule

// File: rtl/radio_frame_rx.sv
module radio_frame_rx
    import radio_rx_pkg::*;
#(
    parameter logic [15:0] DELIM_PATTERN = 16'hF3A5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    output logic       hdr_valid,
    output logic [5:0] hdr_tx_addr,
    output logic [5:0] hdr_rx_addr,
    output logic [5:0] hdr_src_addr,
    output logic [5:0] hdr_dst_addr,
    output logic [2:0] hdr_kind,
    output logic       hdr_ack,
    output logic       hdr_rsvd,
    output logic [7:0] hdr_seq,
    output logic       hdr_more,
    output logic [5:0] frm_len,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       byte_last,
    output logic       frame_done,
    output logic       crc_ok
);

    localparam int DELIM_W = $bits(DELIM_PATTERN);

    logic             hunt_en;
    logic             delim_hit;
    logic             crc_init;
    logic             crc_en;
    logic [CRC_W-1:0] crc_val;
    mac_hdr_t         hdr;

    delim_detect #(
        .W       (DELIM_W),
        .PATTERN (DELIM_PATTERN)
    ) u_delim (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (hunt_en),
        .bit_in (rx_bit),
        .hit    (delim_hit)
    );

    crc16_serial #(
        .W    (CRC_W),
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .en     (crc_en),
        .bit_in (rx_bit),
        .crc    (crc_val)
    );

    frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .delim_hit  (delim_hit),
        .crc_calc   (crc_val),
        .hunt_en    (hunt_en),
        .crc_init   (crc_init),
        .crc_en     (crc_en),
        .hdr_valid  (hdr_valid),
        .hdr_q      (hdr),
        .frm_len    (frm_len),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_last  (byte_last),
        .frame_done (frame_done),
        .crc_ok     (crc_ok)
    );

    assign hdr_tx_addr  = hdr.tx_addr;
    assign hdr_rx_addr  = hdr.rx_addr;
    assign hdr_src_addr = hdr.src_addr;
    assign hdr_dst_addr = hdr.dst_addr;
    assign hdr_kind     = hdr.kind;
    assign hdr_ack      = hdr.ack;
    assign hdr_rsvd     = hdr.rsvd;
    assign hdr_seq      = hdr.seq;
    assign hdr_more     = hdr.more;

endmodule

// File: tb/radio_frame_rx_tb.sv
module radio_frame_rx_tb;

    localparam logic [15:0] DELIM = 16'hF3A5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_bit;
    logic       hdr_valid, hdr_ack, hdr_rsvd, hdr_more;
    logic [5:0] hdr_tx_addr, hdr_rx_addr, hdr_src_addr, hdr_dst_addr, frm_len;
    logic [2:0] hdr_kind;
    logic [7:0] hdr_seq, byte_data;
    logic       byte_valid, byte_last, frame_done, crc_ok;

    always #5 clk = ~clk;

    radio_frame_rx #(.DELIM_PATTERN(DELIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .hdr_valid(hdr_valid), .hdr_tx_addr(hdr_tx_addr), .hdr_rx_addr(hdr_rx_addr),
        .hdr_src_addr(hdr_src_addr), .hdr_dst_addr(hdr_dst_addr), .hdr_kind(hdr_kind),
        .hdr_ack(hdr_ack), .hdr_rsvd(hdr_rsvd), .hdr_seq(hdr_seq), .hdr_more(hdr_more),
        .frm_len(frm_len), .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_last(byte_last), .frame_done(frame_done), .crc_ok(crc_ok)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    int          nhdr, ngot, nlast, last_at, ndone, nok, stray, multi;
    logic [37:0] cap_hdr;
    logic [5:0]  cap_len;
    logic [7:0]  got [0:255];

    task automatic clr_mon();
        nhdr = 0; ngot = 0; nlast = 0; last_at = -1;
        ndone = 0; nok = 0; stray = 0; multi = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (ngot < 256) got[ngot] = byte_data;
                if (byte_last) begin
                    nlast++;
                    last_at = ngot;
                end
                ngot++;
            end
            if (hdr_valid) begin
                nhdr++;
                cap_hdr = {hdr_tx_addr, hdr_rx_addr, hdr_src_addr, hdr_dst_addr,
                           hdr_kind, hdr_ack, hdr_rsvd, hdr_seq, hdr_more};
                cap_len = frm_len;
            end
            if (frame_done) begin
                ndone++;
                if (crc_ok) nok++;
            end
            if (crc_ok && !frame_done) stray++;
            if (byte_last && !byte_valid) stray++;
            if ((32'(hdr_valid) + 32'(byte_valid) + 32'(frame_done)) > 1) multi++;
        end
    end

    // ---------------- stimulus model ----------------
    logic       sbits [0:2047];
    int         nb;
    logic [7:0] pay [0:63];

    task automatic add_bit(logic b);
        sbits[nb] = b;
        nb++;
    endtask

    task automatic add_field(logic [63:0] v, int w);
        for (int i = w - 1; i >= 0; i--) add_bit(v[i]);
    endtask

    function automatic logic [15:0] crc_of(int from, int upto);
        logic [15:0] c = 16'hFFFF;
        logic        fb;
        for (int i = from; i <= upto; i++) begin
            fb = c[15] ^ sbits[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    // guard zeros + alternating preamble keep any early delimiter match impossible
    task automatic build_frame(int len, logic [37:0] h, bit bad_crc, bit with_pre);
        int          body;
        logic [15:0] c;
        nb = 0;
        if (with_pre) begin
            for (int i = 0; i < 8; i++) add_bit(1'b0);
            for (int i = 0; i < 24; i++) add_bit((i % 2) == 0);
        end
        add_field(64'(DELIM), 16);
        body = nb;
        add_field(64'(len), 6);
        add_field(64'(h), 38);
        for (int j = 0; j < len; j++) add_field(64'(pay[j]), 8);
        c = crc_of(body, nb - 1);
        if (bad_crc) c[0] = ~c[0];
        add_field(64'(c), 16);
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        rx_bit = b;
    endtask

    task automatic send_built();
        for (int i = 0; i < nb; i++) send_bit(sbits[i]);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
        @(posedge clk);
        #1;
    endtask

    // random bits that never complete the delimiter (preceding bits assumed zero)
    task automatic send_noise(int n);
        logic [15:0] bw = '0;
        logic        b;
        for (int i = 0; i < n; i++) begin
            b = 1'($urandom % 2);
            if ({bw[14:0], b} == DELIM) b = ~b;
            bw = {bw[14:0], b};
            send_bit(b);
        end
    endtask

    function automatic logic [37:0] rand_hdr();
        return {6'($urandom), 32'($urandom)};
    endfunction

    task automatic check_frame(string tag, int len, logic [37:0] h, int exp_ok);
        int mism = 0;
        check(nhdr == 1, "R4", {tag, " header strobes"}, nhdr, 1);
        check(cap_hdr == h, "R4", {tag, " header fields"}, cap_hdr, h);
        check(cap_len == 6'(len), "R3", {tag, " length"}, cap_len, len);
        check(ngot == len, (len == 0) ? "R6" : "R5", {tag, " byte count"}, ngot, len);
        for (int j = 0; j < len && j < ngot; j++)
            if (got[j] != pay[j]) mism++;
        check(mism == 0, "R5", {tag, " byte values"}, mism, 0);
        if (len > 0)
            check(nlast == 1 && last_at == len - 1, "R5", {tag, " last marker"}, last_at, len - 1);
        else
            check(nlast == 0, "R6", {tag, " no last marker"}, nlast, 0);
        check(ndone == 1, "R7", {tag, " done strobes"}, ndone, 1);
        check(nok == exp_ok, "R7", {tag, " check result"}, nok, exp_ok);
        check(stray == 0, "R8", {tag, " result outside done"}, stray, 0);
        check(multi == 0, "R10", {tag, " overlapping strobes"}, multi, 0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [37:0] h, h2;
        int          len, bad;
        void'($urandom(32'h2468_ACE1));
        rst_n  = 1'b0;
        rx_bit = 1'b0;
        clr_mon();
        repeat (3) @(negedge clk);
        check({hdr_valid, byte_valid, byte_last, frame_done, crc_ok} == 5'b0, "R1",
              "strobes in reset", {hdr_valid, byte_valid, byte_last, frame_done, crc_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({hdr_valid, byte_valid, byte_last, frame_done, crc_ok} == 5'b0, "R1",
              "strobes after reset", {hdr_valid, byte_valid, byte_last, frame_done, crc_ok}, 0);

        // R2: noise alone
        clr_mon();
        send_noise(400);
        idle(2);
        check(nhdr + ngot + ndone == 0, "R2", "noise produced strobes", nhdr + ngot + ndone, 0);

        // R2: 15-bit prefix only
        clr_mon();
        for (int i = 15; i >= 1; i--) send_bit(DELIM[i]);
        idle(20);
        check(nhdr + ngot + ndone == 0, "R2", "partial delimiter", nhdr + ngot + ndone, 0);

        // R2 + R3 + R4: partial prefix followed by full frame
        clr_mon();
        for (int i = 15; i >= 1; i--) send_bit(DELIM[i]);
        h = 38'h2A_5555_AAAA;
        for (int j = 0; j < 2; j++) pay[j] = 8'(j + 8'h40);
        build_frame(2, h, 0, 1);
        send_built();
        idle(2);
        check_frame("R2 prefix-then-frame", 2, h, 1);

        // R6: zero-length frame
        clr_mon();
        h = rand_hdr();
        build_frame(0, h, 0, 1);
        send_built();
        idle(2);
        check_frame("R6 header-only", 0, h, 1);

        // R5: maximum length
        clr_mon();
        h = rand_hdr();
        for (int j = 0; j < 63; j++) pay[j] = 8'($urandom);
        build_frame(63, h, 0, 1);
        send_built();
        idle(2);
        check_frame("R5 max length", 63, h, 1);

        // R9: delimiter pattern inside payload
        clr_mon();
        h = rand_hdr();
        pay[0] = DELIM[15:8]; pay[1] = DELIM[7:0];
        pay[2] = DELIM[15:8]; pay[3] = DELIM[7:0];
        build_frame(4, h, 0, 1);
        send_built();
        idle(2);
        check_frame("R9 embedded delimiter", 4, h, 1);

        // R7: corrupted check word
        clr_mon();
        h = rand_hdr();
        for (int j = 0; j < 5; j++) pay[j] = 8'($urandom);
        build_frame(5, h, 1, 1);
        send_built();
        idle(2);
        check_frame("R7 bad check", 5, h, 0);

        // R9: back-to-back frames, second delimiter right after first check word
        clr_mon();
        h = rand_hdr();
        for (int j = 0; j < 3; j++) pay[j] = 8'($urandom);
        build_frame(3, h, 0, 1);
        send_built();
        h2 = rand_hdr();
        for (int j = 0; j < 2; j++) pay[j] = 8'($urandom);
        build_frame(2, h2, 0, 0);
        send_built();
        idle(2);
        check(ndone == 2 && nok == 2, "R9", "back-to-back frames done/ok", {ndone, nok}, {2, 2});
        check(nhdr == 2 && ngot == 5, "R9", "back-to-back hdr/bytes", {nhdr, ngot}, {2, 5});
        check(cap_hdr == h2, "R9", "second header", cap_hdr, h2);
        check(got[3] == pay[0] && got[4] == pay[1], "R9", "second payload",
              {got[3], got[4]}, {pay[0], pay[1]});

        // random frames
        for (int k = 0; k < 24; k++) begin
            clr_mon();
            send_noise(int'($urandom % 40));
            len = int'($urandom % 64);
            bad = ($urandom % 4) == 0;
            h   = rand_hdr();
            for (int j = 0; j < len; j++) pay[j] = 8'($urandom);
            build_frame(len, h, bit'(bad), 1);
            send_built();
            idle(2);
            check_frame("random", len, h, bad ? 0 : 1);
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule